// File: doc/BRIEF.md
# Banked Interrupt Group Distributor Registers

This block is the register front end of an interrupt distributor. It accepts one access at a time. Each access carries a byte offset, a direction, a write byte, a secure or non-secure attribute and the index of the requesting CPU. The block holds three things: the distributor control word with one enable per interrupt group, a read-only description word, and one group-select bit per interrupt line. It drives the two group enables and the full group-select vector to the priority logic that follows. That logic does the arbitration, tracks pending and active state and signals the CPUs, and is not part of this block.

Two parameters decide what the block exposes. One is a revision code and the other is a security-extension switch. Together they decide whether grouping exists, whether non-secure accesses see a reduced view, and whether the configuration is legal. Lines 0 to 31 are private to each CPU. Each of these lines keeps one group bit per CPU, and a write changes only the copy of the CPU that made the request. Lines 32 and above keep a single bit that all CPUs share.

A three-state machine sequences every access. ST_IDLE raises `req_ready` and goes to ST_EXEC when `req_valid` is seen, latching the request (transition ACCEPT). ST_EXEC decodes the request, applies any write and registers the read data and the error flag, then goes to ST_RESP (transition EXECUTE). ST_RESP raises `rsp_valid` for one cycle and returns to ST_IDLE (transition COMPLETE).

Top module: `irq_group_regs`

## Requirements
- R1: After reset the control word is 0, both group enables are low, every group-select bit (private and shared) is 0, `req_ready` is high and `rsp_valid` is low.
- R2: An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the following cycle. `rsp_valid` is high for exactly one cycle, in the second cycle after acceptance, and carries `rsp_rdata` and `rsp_err` in that cycle.
- R3: Offset 0x00 is the control word: bit 0 enables group 0 and bit 1 enables group 1. When grouping exists, a secure write, or any write when security is absent, stores write bits [1:0]. A read in the same view returns them in bits [1:0]. `en_grp0` and `en_grp1` follow the stored bits.
- R4: When security is present, a non-secure read of offset 0x00 returns stored bit 1 in bit 0 and zeros elsewhere. A non-secure write copies write bit 0 into stored bit 1 and leaves stored bit 0 unchanged.
- R5: When grouping is absent, a write of offset 0x00 stores only write bit 0, and stored bit 1 stays 0. Grouping exists when the revision code is 2 or when security is present.
- R6: Offset 0x04 reads as (NUM_IRQ/32 - 1) in bits [4:0], OR (NUM_CPU - 1) in bits [7:5], OR the security-present flag in bit 10. Writes to it have no effect.
- R7: Offset 0x80+n is a group byte. Bit i selects interrupt 8n+i, where 1 means group 1 and 0 means group 0. A write replaces all eight bits and a read returns them.
- R8: For interrupts 0 to 31, writes and reads use only the copy of the requesting CPU. The copies of the other CPUs stay unchanged. Copy c appears on `grp_private[32c+31:32c]`.
- R9: For interrupts 32 and above there is one copy, which every CPU reads and writes. Interrupt k appears on `grp_shared[k-32]`.
- R10: The group bytes read as zero, ignore writes and report no error when grouping is absent, or when security is present and the access is non-secure.
- R11: An accessible group byte whose first interrupt index is at or above NUM_IRQ answers with `rsp_err` = 1 and read data 0, and changes no state.
- R12: Offsets 0x01 to 0x03 and 0x05 to 0x7F read as zero, ignore writes and report no error.
- R13: Enabling security with revision code 0 or 0xFFFFFFFF is an illegal configuration. `cfg_error` is then high, every access answers with `rsp_err` = 1, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 8 | Write byte |
| req_secure | input | 1 | 1 = secure access |
| req_cpu | input | CPU_W | Requesting CPU index |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |
| cfg_error | output | 1 | Illegal parameter combination |
| en_grp0 | output | 1 | Group 0 enable |
| en_grp1 | output | 1 | Group 1 enable |
| grp_private | output | 32*NUM_CPU | Per-CPU group bits of interrupts 0..31 |
| grp_shared | output | NUM_IRQ-32 | Group bits of interrupts 32 and up |

## Verification
Two behaviours meet in a single ST_EXEC cycle: the read mux samples the group storage, and the same cycle's write enable updates it. A read must therefore see the state from before any write, and a rejected access (out of range, muted, or illegal configuration) must leave the storage untouched while still returning its response. The bench provokes both with long random runs that mix secure and non-secure attributes, all four CPU indices and group offsets just beyond NUM_IRQ. After every access it compares read data, the error flag and the whole exported vector against a bench model. Directed cases cover the reduced non-secure view of the control word, banking across CPUs, and separate instances in which grouping is absent or the configuration is illegal.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_RESP
    } fsm_state_t;

    typedef enum logic [2:0] {
        AK_CTRL,
        AK_DESC,
        AK_RSVD,
        AK_GROUP,
        AK_MUTE
    } acc_kind_t;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DESC = 8'h04;

    function automatic bit grouping_present(input int unsigned rev, input bit sec);
        return (rev == 2) || sec;
    endfunction

    function automatic bit config_illegal(input int unsigned rev, input bit sec);
        return sec && ((rev == 0) || (rev == 32'hFFFF_FFFF));
    endfunction

endpackage

// File: rtl/grp_access_decode.sv
module grp_access_decode
    import irq_group_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter bit SEC_EXT = 1'b1,
    parameter bit GROUPS  = 1'b1
) (
    input  logic [7:0] addr,
    input  logic       secure,
    output acc_kind_t  kind,
    output logic [6:0] byte_idx,
    output logic       range_err
);
    localparam int NUM_BYTES = NUM_IRQ / 8;

    always_comb begin
        byte_idx  = addr[6:0];
        range_err = 1'b0;
        if (addr == OFS_CTRL) begin
            kind = AK_CTRL;
        end else if (addr == OFS_DESC) begin
            kind = AK_DESC;
        end else if (!addr[7]) begin
            kind = AK_RSVD;
        end else if (!GROUPS || (SEC_EXT && !secure)) begin
            kind = AK_MUTE;
        end else begin
            kind      = AK_GROUP;
            range_err = (32'(addr[6:0]) >= NUM_BYTES);
        end
    end
endmodule

// File: rtl/dist_ctrl_bank.sv
module dist_ctrl_bank #(
    parameter bit SEC_EXT = 1'b1,
    parameter bit GROUPS  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       secure,
    input  logic [1:0] wbits,
    output logic [1:0] rd_view,
    output logic [1:0] ctrl
);
    logic [1:0] ctrl_q;
    logic       ns_view;

    assign ns_view = SEC_EXT && !secure;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
        end else if (wr_en) begin
            if (ns_view) begin
                ctrl_q[1] <= wbits[0];
            end else if (GROUPS) begin
                ctrl_q <= wbits;
            end else begin
                ctrl_q <= {1'b0, wbits[0]};
            end
        end
    end

    assign rd_view = ns_view ? {1'b0, ctrl_q[1]} : ctrl_q;
    assign ctrl    = ctrl_q;

    // R4
    ns_keeps_en0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ns_view) |=> (ctrl_q[0] == $past(ctrl_q[0])));

    // R5
    nogrp_en1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !GROUPS) |=> !ctrl_q[1]);
endmodule

// File: rtl/grp_bit_bank.sv
module grp_bit_bank #(
    parameter int NUM_IRQ = 96,
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CPU_W-1:0]        cpu,
    input  logic [6:0]              byte_idx,
    input  logic [7:0]              wbyte,
    output logic [7:0]              rd_byte,
    output logic [NUM_CPU*32-1:0]   priv_flat,
    output logic [NUM_IRQ-33:0]     shared_flat
);
    localparam int NSH       = NUM_IRQ - 32;
    localparam int SH_BYTES  = NSH / 8;

    logic [NUM_CPU-1:0][31:0] priv_q;
    logic [NSH-1:0]           shr_q;
    logic                     is_private;
    logic [NSH-1:0]           shr_shift;

    assign is_private = (byte_idx < 7'd4);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar b = 0; b < 4; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    priv_q[c][b*8 +: 8] <= 8'h00;
                end else if (wr_en && (32'(cpu) == c) && (byte_idx == 7'(b))) begin
                    priv_q[c][b*8 +: 8] <= wbyte;
                end
            end
        end

        // R8
        bank_other_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && is_private && (32'(cpu) != c)) |=> $stable(priv_q[c]));
    end

    for (genvar b = 0; b < SH_BYTES; b++) begin : g_shared
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shr_q[b*8 +: 8] <= 8'h00;
            end else if (wr_en && (byte_idx == 7'(b + 4))) begin
                shr_q[b*8 +: 8] <= wbyte;
            end
        end
    end

    assign shr_shift = shr_q >> {byte_idx - 7'd4, 3'b000};

    always_comb begin
        if (is_private) begin
            rd_byte = priv_q[cpu][{byte_idx[1:0], 3'b000} +: 8];
        end else begin
            rd_byte = shr_shift[7:0];
        end
    end

    assign priv_flat   = priv_q;
    assign shared_flat = shr_q;

    // R10
    idle_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(priv_q) && $stable(shr_q)));
endmodule

// File: rtl/irq_group_regs.sv
module irq_group_regs
    import irq_group_pkg::*;
#(
    parameter int          NUM_IRQ  = 96,
    parameter int          NUM_CPU  = 4,
    parameter int unsigned REVISION = 1,
    parameter bit          SEC_EXT  = 1'b1,
    localparam int         CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [7:0]            req_addr,
    input  logic [7:0]            req_wdata,
    input  logic                  req_secure,
    input  logic [CPU_W-1:0]      req_cpu,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_err,
    output logic                  cfg_error,
    output logic                  en_grp0,
    output logic                  en_grp1,
    output logic [NUM_CPU*32-1:0] grp_private,
    output logic [NUM_IRQ-33:0]   grp_shared
);
    localparam bit          GROUPS    = grouping_present(REVISION, SEC_EXT);
    localparam bit          BAD_CFG   = config_illegal(REVISION, SEC_EXT);
    localparam logic [31:0] DESC_WORD = 32'(NUM_IRQ / 32 - 1)
                                      | (32'(NUM_CPU - 1) << 5)
                                      | (32'(SEC_EXT) << 10);

    fsm_state_t       state_q, state_d;
    logic             q_write, q_secure;
    logic [7:0]       q_addr, q_wdata;
    logic [CPU_W-1:0] q_cpu;

    acc_kind_t        kind;
    logic [6:0]       byte_idx;
    logic             range_err;
    logic             cpu_oob;
    logic             acc_err;
    logic             wr_ctrl, wr_grp;
    logic [1:0]       ctrl_view, ctrl_bits;
    logic [7:0]       grp_byte;
    logic [31:0]      rd_mux;
    logic             in_exec;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;   // ACCEPT
            ST_EXEC: state_d = ST_RESP;                  // EXECUTE
            ST_RESP: state_d = ST_IDLE;                  // COMPLETE
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        in_exec   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EXEC: in_exec   = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    // ---------------- request latch ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write  <= 1'b0;
            q_secure <= 1'b0;
            q_addr   <= 8'h00;
            q_wdata  <= 8'h00;
            q_cpu    <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            q_write  <= req_write;
            q_secure <= req_secure;
            q_addr   <= req_addr;
            q_wdata  <= req_wdata;
            q_cpu    <= req_cpu;
        end
    end

    grp_access_decode #(
        .NUM_IRQ (NUM_IRQ),
        .SEC_EXT (SEC_EXT),
        .GROUPS  (GROUPS)
    ) u_decode (
        .addr      (q_addr),
        .secure    (q_secure),
        .kind      (kind),
        .byte_idx  (byte_idx),
        .range_err (range_err)
    );

    assign cpu_oob = ({1'b0, q_cpu} >= (CPU_W+1)'(NUM_CPU));
    assign acc_err = BAD_CFG || range_err || cpu_oob;
    assign wr_ctrl = in_exec && q_write && (kind == AK_CTRL)  && !acc_err;
    assign wr_grp  = in_exec && q_write && (kind == AK_GROUP) && !acc_err;

    dist_ctrl_bank #(
        .SEC_EXT (SEC_EXT),
        .GROUPS  (GROUPS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .secure  (q_secure),
        .wbits   (q_wdata[1:0]),
        .rd_view (ctrl_view),
        .ctrl    (ctrl_bits)
    );

    grp_bit_bank #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_grp),
        .cpu         (q_cpu),
        .byte_idx    (byte_idx),
        .wbyte       (q_wdata),
        .rd_byte     (grp_byte),
        .priv_flat   (grp_private),
        .shared_flat (grp_shared)
    );

    always_comb begin
        rd_mux = 32'h0;
        if (!acc_err) begin
            unique case (kind)
                AK_CTRL:  rd_mux = {30'h0, ctrl_view};
                AK_DESC:  rd_mux = DESC_WORD;
                AK_GROUP: rd_mux = {24'h0, grp_byte};
                AK_RSVD:  rd_mux = 32'h0;
                AK_MUTE:  rd_mux = 32'h0;
                default:  rd_mux = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= 32'h0;
            rsp_err   <= 1'b0;
        end else if (in_exec) begin
            rsp_rdata <= rd_mux;
            rsp_err   <= acc_err;
        end
    end

    assign cfg_error = BAD_CFG;
    assign en_grp0   = ctrl_bits[0];
    assign en_grp1   = ctrl_bits[1];

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    resp_two_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    // R2
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && acc_err) |=> ($stable(grp_private) && $stable(grp_shared)
                                  && $stable({en_grp1, en_grp0})));
endmodule

// File: tb/irq_group_regs_tb.sv
module irq_group_regs_tb;
    localparam int NIRQ = 96;
    localparam int NCPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  rv = '0, rw = '0, rs = '0;
    logic [7:0]  ra [3];
    logic [7:0]  rwd [3];
    logic [1:0]  rc [3];
    logic [2:0]  rdy, rspv, rerr, cfe, e0, e1;
    logic [31:0] rr [3];
    logic [127:0] gp [3];
    logic [63:0]  gs [3];

    int n_chk = 0;
    int n_fail = 0;

    // d=0 main (security, grouping); d=1 no grouping; d=2 illegal config
    irq_group_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(1), .SEC_EXT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw[0]), .req_addr(ra[0]),
        .req_wdata(rwd[0]), .req_secure(rs[0]), .req_cpu(rc[0]), .req_ready(rdy[0]),
        .rsp_valid(rspv[0]), .rsp_rdata(rr[0]), .rsp_err(rerr[0]), .cfg_error(cfe[0]),
        .en_grp0(e0[0]), .en_grp1(e1[0]), .grp_private(gp[0]), .grp_shared(gs[0]));

    irq_group_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(1), .SEC_EXT(1'b0)) u_nogrp (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw[1]), .req_addr(ra[1]),
        .req_wdata(rwd[1]), .req_secure(rs[1]), .req_cpu(rc[1]), .req_ready(rdy[1]),
        .rsp_valid(rspv[1]), .rsp_rdata(rr[1]), .rsp_err(rerr[1]), .cfg_error(cfe[1]),
        .en_grp0(e0[1]), .en_grp1(e1[1]), .grp_private(gp[1]), .grp_shared(gs[1]));

    irq_group_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(0), .SEC_EXT(1'b1)) u_bad (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_write(rw[2]), .req_addr(ra[2]),
        .req_wdata(rwd[2]), .req_secure(rs[2]), .req_cpu(rc[2]), .req_ready(rdy[2]),
        .rsp_valid(rspv[2]), .rsp_rdata(rr[2]), .rsp_err(rerr[2]), .cfg_error(cfe[2]),
        .en_grp0(e0[2]), .en_grp1(e1[2]), .grp_private(gp[2]), .grp_shared(gs[2]));

    // bench model of the main instance
    logic [1:0]   m_ctrl = 2'b00;
    logic [127:0] m_priv = '0;
    logic [63:0]  m_shr  = '0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input int d, input bit wr, input logic [7:0] a, input logic [7:0] wd,
                       input bit sec, input logic [1:0] cpu,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        rv[d] = 1'b1; rw[d] = wr; ra[d] = a; rwd[d] = wd; rs[d] = sec; rc[d] = cpu;
        @(negedge clk);
        rv[d] = 1'b0;
        // R2: one cycle after acceptance: not ready, no response yet
        chk(!rdy[d] && !rspv[d], "R2 busy", {rdy[d], rspv[d]}, 2'b00);
        @(negedge clk);
        chk(rspv[d] === 1'b1, "R2 response", rspv[d], 1);
        rd = rr[d];
        er = rerr[d];
    endtask

    // expected result for the main instance, updating the model
    task automatic model(input bit wr, input logic [7:0] a, input logic [7:0] wd, input bit sec,
                         input logic [1:0] cpu, output logic [31:0] erd, output logic eer);
        int n;
        erd = 0; eer = 0;
        if (a == 8'h00) begin
            if (!sec) begin
                erd = {31'b0, m_ctrl[1]};
                if (wr) m_ctrl[1] = wd[0];
            end else begin
                erd = {30'b0, m_ctrl};
                if (wr) m_ctrl = wd[1:0];
            end
        end else if (a == 8'h04) begin
            erd = 32'h462;
        end else if (a >= 8'h80 && sec) begin
            n = int'(a) - 8'h80;
            if (n * 8 >= NIRQ) begin
                eer = 1;
            end else if (n < 4) begin
                erd = {24'b0, m_priv[cpu*32 + n*8 +: 8]};
                if (wr) m_priv[cpu*32 + n*8 +: 8] = wd;
            end else begin
                erd = {24'b0, m_shr[(n-4)*8 +: 8]};
                if (wr) m_shr[(n-4)*8 +: 8] = wd;
            end
        end
    endtask

    task automatic run_main(input bit wr, input logic [7:0] a, input logic [7:0] wd, input bit sec,
                            input logic [1:0] cpu, input string tag);
        logic [31:0] rd, erd;
        logic er, eer;
        model(wr, a, wd, sec, cpu, erd, eer);
        acc(0, wr, a, wd, sec, cpu, rd, er);
        chk(rd == erd && er == eer, tag, {er, rd}, {eer, erd});
        chk(gp[0] == m_priv, "R8 private vector", gp[0], m_priv);
        chk(gs[0] == m_shr, "R9 shared vector", gs[0], m_shr);
        chk({e1[0], e0[0]} == m_ctrl, "R3 enables", {e1[0], e0[0]}, m_ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic er;
        void'($urandom(32'd4711));
        for (int i = 0; i < 3; i++) begin
            ra[i] = 0; rwd[i] = 0; rc[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdy[0] && !rspv[0], "R1 handshake idle", {rdy[0], rspv[0]}, 2'b10);
        chk(!e0[0] && !e1[0] && gp[0] == 0 && gs[0] == 0, "R1 state clear", {e1[0], e0[0]}, 0);

        // R6 description word, both views, write ignored
        run_main(1'b0, 8'h04, 8'h00, 1'b1, 2'd0, "R6 desc secure");
        run_main(1'b1, 8'h04, 8'hFF, 1'b0, 2'd1, "R6 desc write ignored");
        run_main(1'b0, 8'h04, 8'h00, 1'b0, 2'd1, "R6 desc nonsecure");
        // R3 secure control write
        run_main(1'b1, 8'h00, 8'h03, 1'b1, 2'd0, "R3 ctrl write");
        run_main(1'b0, 8'h00, 8'h00, 1'b1, 2'd0, "R3 ctrl read");
        // R4 non-secure alias
        run_main(1'b1, 8'h00, 8'h00, 1'b0, 2'd2, "R4 ns clears en1 only");
        run_main(1'b0, 8'h00, 8'h00, 1'b0, 2'd2, "R4 ns read");
        run_main(1'b1, 8'h00, 8'h01, 1'b0, 2'd2, "R4 ns sets en1");
        run_main(1'b0, 8'h00, 8'h00, 1'b1, 2'd2, "R4 secure sees both");
        // R7/R8 private banking
        run_main(1'b1, 8'h80, 8'hA5, 1'b1, 2'd1, "R7 private write cpu1");
        run_main(1'b0, 8'h80, 8'h00, 1'b1, 2'd1, "R8 cpu1 reads own");
        run_main(1'b0, 8'h80, 8'h00, 1'b1, 2'd3, "R8 cpu3 copy untouched");
        // R9 shared
        run_main(1'b1, 8'h8B, 8'h81, 1'b1, 2'd0, "R9 shared write top byte");
        run_main(1'b0, 8'h8B, 8'h00, 1'b1, 2'd3, "R9 shared read other cpu");
        // R10 non-secure group access muted
        run_main(1'b1, 8'h8B, 8'h00, 1'b0, 2'd0, "R10 ns group write ignored");
        run_main(1'b0, 8'h84, 8'h00, 1'b0, 2'd0, "R10 ns group reads zero");
        // R11 out of range
        run_main(1'b1, 8'h8C, 8'hFF, 1'b1, 2'd0, "R11 first index at NUM_IRQ");
        run_main(1'b0, 8'hFF, 8'h00, 1'b1, 2'd2, "R11 top offset");
        // R12 reserved
        run_main(1'b1, 8'h02, 8'hFF, 1'b1, 2'd0, "R12 reserved write");
        run_main(1'b0, 8'h7F, 8'h00, 1'b1, 2'd0, "R12 reserved read");

        // constrained random on the main instance
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 6);
            case (sel)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'($urandom_range(5, 127));
                default: a = 8'h80 + 8'($urandom_range(0, 13));
            endcase
            run_main(1'($urandom_range(0, 1)), a, 8'($urandom), ($urandom_range(0, 3) != 0),
                     2'($urandom_range(0, 3)), "R7 random access");
        end

        // R5 / R10 no grouping instance
        acc(1, 1'b1, 8'h00, 8'h03, 1'b1, 2'd0, rd, er);
        chk(e0[1] && !e1[1], "R5 ctrl keeps bit0 only", {e1[1], e0[1]}, 2'b01);
        acc(1, 1'b0, 8'h00, 8'h00, 1'b0, 2'd0, rd, er);
        chk(rd == 32'h1 && !er, "R5 ctrl read", rd, 1);
        acc(1, 1'b1, 8'h80, 8'hFF, 1'b1, 2'd0, rd, er);
        chk(gp[1] == 0 && !er, "R10 nogrp write ignored", gp[1], 0);
        acc(1, 1'b0, 8'h85, 8'h00, 1'b1, 2'd0, rd, er);
        chk(rd == 0 && !er, "R10 nogrp reads zero", rd, 0);
        acc(1, 1'b0, 8'h04, 8'h00, 1'b1, 2'd0, rd, er);
        chk(rd == 32'h62, "R6 desc without security", rd, 32'h62);

        // R13 illegal configuration
        chk(cfe[2] && !cfe[0] && !cfe[1], "R13 cfg_error", cfe, 3'b100);
        acc(2, 1'b1, 8'h00, 8'h03, 1'b1, 2'd0, rd, er);
        chk(er && !e0[2] && !e1[2], "R13 ctrl write rejected", {er, e1[2], e0[2]}, 3'b100);
        acc(2, 1'b1, 8'h80, 8'hFF, 1'b1, 2'd0, rd, er);
        chk(er && gp[2] == 0, "R13 group write rejected", gp[2], 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule